// File: doc/BRIEF.md
# Syndrome Nearest-Match Fault Diagnoser

This block runs a short fixed test program against a small combinational circuit under test and names the most likely fault. After a start pulse it drives one stored input vector per clock cycle onto a 3-bit bus. On the edge that ends each vector's cycle it samples the single response bit and compares it with the expected bit held in a golden register. Each mismatch sets one bit of a pass/fail syndrome word.

Once the last test has been sampled, the block walks a dictionary of syndrome entries held in registers. It visits one entry per cycle and keeps the valid entry whose syndrome has the smallest Hamming distance to the observed one. An exact match gives distance zero. A fault outside the stuck-at set, such as a swapped gate or a bridge between two lines, still yields the nearest listed fault class.

The golden word and the dictionary entries are loaded through simple write ports before a run starts.

Top module: `fdd_top`

## Requirements
- R1: After the clock edge that accepts a start, `cut_in` carries the test vectors one per cycle in this fixed order: 3'b010, 3'b011, 3'b100, 3'b110. Whenever no test is running, `cut_in` is 3'b000.
- R2: Syndrome bit k is `cut_resp` sampled at the end of the cycle that drives vector k, XORed with bit k of the golden word written by `gold_we`/`gold_data`. Bit 0 belongs to the first vector. A set bit means that test failed.
- R3: The dictionary holds 16 entries, each with a 4-bit syndrome and a valid flag, written through `dict_we`/`dict_addr`/`dict_syn`/`dict_vld`. An entry whose valid flag is 0 is never reported, even if it matches exactly.
- R4: The result is the valid entry with the minimum Hamming distance to the syndrome. `fault_idx` gives its address and `fault_dist` its distance, and an exact match gives distance 0.
- R5: When several valid entries share the minimum distance, the lowest address wins.
- R6: If no entry is valid, `hit` is 0 and `fault_idx` and `fault_dist` are both 0. Otherwise `hit` is 1.
- R7: `done` is high for exactly one cycle. It is seen after the 22nd rising edge, counting the edge that accepts start as the first (tests + entries + 2).
- R8: `hit`, `fault_idx` and `fault_dist` change only in the cycle where `done` is high. They hold their values after that, even if the dictionary or the golden word is rewritten.
- R9: A start pulse that arrives while a run is still in progress is ignored. It neither restarts the run nor causes a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a diagnosis run |
| cut_in | output | 3 | Drive bus to the circuit under test |
| cut_resp | input | 1 | Response bit from the circuit under test |
| gold_we | input | 1 | Write strobe for the golden word |
| gold_data | input | 4 | Expected response bits, bit k for test k |
| dict_we | input | 1 | Dictionary write strobe |
| dict_addr | input | 4 | Dictionary entry address |
| dict_syn | input | 4 | Syndrome stored in the addressed entry |
| dict_vld | input | 1 | Valid flag stored in the addressed entry |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A valid entry was found |
| fault_idx | output | 4 | Address of the nearest entry |
| fault_dist | output | 3 | Hamming distance to that entry |

## Verification
The bench drives the response from its own model of a fault-free circuit and inverts chosen tests to produce syndromes with known answers. The all-pass pattern must select the zero-syndrome entry. A pattern equal to a stored entry separates exact matching from mere proximity. Patterns that fall between entries check the distance arithmetic and the lowest-address rule on ties. A pattern that exactly matches a disabled entry shows that the valid flag is honoured, and rewriting the golden word with the response left unchanged shows that the syndrome depends on the expected value.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

   // Number of set bits in a word of up to 32 bits
   function automatic int unsigned popcnt(input logic [31:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) n += int'(v[i]);
      return n;
   endfunction

endpackage

// File: rtl/fdd_seq.sv
module fdd_seq #(
   parameter int N    = 4,
   parameter int IN_W = 3,
   parameter logic [N-1:0][IN_W-1:0] TEST_VEC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_ok,
   input  logic            cut_resp,
   input  logic            gold_we,
   input  logic [N-1:0]    gold_data,
   output logic [IN_W-1:0] cut_in,
   output logic            run,
   output logic            fin,
   output logic [N-1:0]    syndrome
);
   localparam int IW = $clog2(N);

   logic [N-1:0]  gold_q;
   logic [IW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gold_q   <= '0;
         syndrome <= '0;
         idx      <= '0;
         run      <= 1'b0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (gold_we) gold_q <= gold_data;
         if (start_ok) begin
            run <= 1'b1;
            idx <= '0;
         end else if (run) begin
            syndrome[idx] <= cut_resp ^ gold_q[idx];
            if (idx == IW'(N - 1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign cut_in = run ? TEST_VEC[idx] : '0;

endmodule

// File: rtl/fdd_dict.sv
module fdd_dict #(
   parameter int N           = 4,
   parameter int DEPTH       = 16,
   parameter bit CLEAR_RESET = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [N-1:0]             wsyn,
   input  logic                     wvld,
   output logic [DEPTH-1:0][N-1:0]  ent_syn,
   output logic [DEPTH-1:0]         ent_vld
);
   localparam int AW = $clog2(DEPTH);

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic sel;
      assign sel = we && (addr == AW'(e));
      if (CLEAR_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_syn[e] <= '0;
               ent_vld[e] <= 1'b0;
            end else if (sel) begin
               ent_syn[e] <= wsyn;
               ent_vld[e] <= wvld;
            end
         end
      end else begin : g_keep
         // only the valid flag is reset; syndromes keep their contents
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_vld[e] <= 1'b0;
            else if (sel) ent_vld[e] <= wvld;
         end
         always_ff @(posedge clk) begin
            if (sel) ent_syn[e] <= wsyn;
         end
      end
   end

endmodule

// File: rtl/fdd_search.sv
module fdd_search #(
   parameter int N     = 4,
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   input  logic [N-1:0]             syndrome,
   input  logic [DEPTH-1:0][N-1:0]  ent_syn,
   input  logic [DEPTH-1:0]         ent_vld,
   output logic                     active,
   output logic                     done,
   output logic                     hit,
   output logic [$clog2(DEPTH)-1:0] fault_idx,
   output logic [$clog2(N+1)-1:0]   fault_dist
);
   import fdd_pkg::*;
   localparam int AW = $clog2(DEPTH);
   localparam int DW = $clog2(N + 1);

   logic [AW-1:0] ptr, best_i;
   logic [DW-1:0] best_d, cur_d;
   logic          found, take;

   always_comb begin
      cur_d = DW'(popcnt(32'(ent_syn[ptr] ^ syndrome)));
      take  = active && ent_vld[ptr] && (!found || (cur_d < best_d));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         ptr        <= '0;
         found      <= 1'b0;
         best_i     <= '0;
         best_d     <= '0;
         done       <= 1'b0;
         hit        <= 1'b0;
         fault_idx  <= '0;
         fault_dist <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            active <= 1'b1;
            ptr    <= '0;
            found  <= 1'b0;
            best_i <= '0;
            best_d <= '0;
         end else if (active) begin
            if (take) begin
               found  <= 1'b1;
               best_i <= ptr;
               best_d <= cur_d;
            end
            if (ptr == AW'(DEPTH - 1)) begin
               active     <= 1'b0;
               done       <= 1'b1;
               hit        <= take | found;
               fault_idx  <= take ? ptr   : best_i;
               fault_dist <= take ? cur_d : best_d;
            end else begin
               ptr <= ptr + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/fdd_top.sv
module fdd_top #(
   parameter int NUM_TESTS  = 4,
   parameter int IN_W       = 3,
   parameter int DICT_DEPTH = 16,
   parameter bit CLEAR_DICT = 1'b1,
   parameter logic [NUM_TESTS-1:0][IN_W-1:0] TEST_VEC =
      {3'b110, 3'b100, 3'b011, 3'b010},
   localparam int AW = $clog2(DICT_DEPTH),
   localparam int DW = $clog2(NUM_TESTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic [IN_W-1:0]      cut_in,
   input  logic                 cut_resp,
   input  logic                 gold_we,
   input  logic [NUM_TESTS-1:0] gold_data,
   input  logic                 dict_we,
   input  logic [AW-1:0]        dict_addr,
   input  logic [NUM_TESTS-1:0] dict_syn,
   input  logic                 dict_vld,
   output logic                 done,
   output logic                 hit,
   output logic [AW-1:0]        fault_idx,
   output logic [DW-1:0]        fault_dist
);
   if (NUM_TESTS < 2 || NUM_TESTS > 32) begin : g_bad_tests
      $error("fdd_top: NUM_TESTS must lie in 2..32");
   end
   if (DICT_DEPTH < 2) begin : g_bad_depth
      $error("fdd_top: DICT_DEPTH must be at least 2");
   end
   if (IN_W < 1) begin : g_bad_inw
      $error("fdd_top: IN_W must be at least 1");
   end

   logic                             seq_run, seq_fin, srch_active, start_ok;
   logic [NUM_TESTS-1:0]             syndrome;
   logic [DICT_DEPTH-1:0][NUM_TESTS-1:0] ent_syn;
   logic [DICT_DEPTH-1:0]            ent_vld;

   assign start_ok = start && !(seq_run || seq_fin || srch_active);

   fdd_seq #(.N(NUM_TESTS), .IN_W(IN_W), .TEST_VEC(TEST_VEC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .cut_resp(cut_resp),
      .gold_we(gold_we), .gold_data(gold_data), .cut_in(cut_in),
      .run(seq_run), .fin(seq_fin), .syndrome(syndrome)
   );

   fdd_dict #(.N(NUM_TESTS), .DEPTH(DICT_DEPTH), .CLEAR_RESET(CLEAR_DICT)) u_dict (
      .clk(clk), .rst_n(rst_n), .we(dict_we), .addr(dict_addr),
      .wsyn(dict_syn), .wvld(dict_vld), .ent_syn(ent_syn), .ent_vld(ent_vld)
   );

   fdd_search #(.N(NUM_TESTS), .DEPTH(DICT_DEPTH)) u_search (
      .clk(clk), .rst_n(rst_n), .go(seq_fin), .syndrome(syndrome),
      .ent_syn(ent_syn), .ent_vld(ent_vld), .active(srch_active),
      .done(done), .hit(hit), .fault_idx(fault_idx), .fault_dist(fault_dist)
   );

endmodule

// File: rtl/fdd_checker.sv
module fdd_checker #(
   parameter int NUM_TESTS = 4,
   parameter int IN_W      = 3,
   parameter int AW        = 4,
   parameter int DW        = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            seq_run,
   input logic [IN_W-1:0] cut_in,
   input logic            done,
   input logic            hit,
   input logic [AW-1:0]   fault_idx,
   input logic [DW-1:0]   fault_dist
);
   AST_DRIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seq_run) |-> cut_in == '0);                                   // R1
   AST_DIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> fault_dist <= DW'(NUM_TESTS));                              // R4
   AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (fault_idx == '0 && fault_dist == '0));                    // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(hit) && $stable(fault_idx) && $stable(fault_dist))); // R8
endmodule

bind fdd_top fdd_checker #(.NUM_TESTS(NUM_TESTS), .IN_W(IN_W), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .seq_run(seq_run), .cut_in(cut_in),
   .done(done), .hit(hit), .fault_idx(fault_idx), .fault_dist(fault_dist)
);

// File: tb/fdd_top_test.sv
module fdd_top_test;
   localparam int N = 4, DEPTH = 16, LAT = N + DEPTH + 2;
   localparam logic [2:0] VEC [N] = '{3'b010, 3'b011, 3'b100, 3'b110};
   localparam logic [N-1:0] TRUE_RESP = 4'b0110; // fault-free response, bit k = test k

   logic clk = 0, rst_n = 0, start = 0, cut_resp;
   logic gold_we = 0, dict_we = 0, dict_vld = 0;
   logic [N-1:0] gold_data = '0, dict_syn = '0;
   logic [3:0] dict_addr = '0;
   logic [2:0] cut_in;
   logic done, hit;
   logic [3:0] fault_idx;
   logic [2:0] fault_dist;

   int checks = 0, errors = 0, cyc = 0;
   logic [N-1:0] flip = '0;
   logic [N-1:0] sh_syn [DEPTH];
   logic         sh_vld [DEPTH];
   logic [N-1:0] sh_gold = '0;

   always #4 clk = ~clk;

   fdd_top uut (.*);

   // circuit-under-test model: fault-free value with chosen tests inverted
   always_comb begin
      cut_resp = 1'b0;
      for (int k = 0; k < N; k++)
         if (cut_in == VEC[k]) cut_resp = TRUE_RESP[k] ^ flip[k];
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: act %0d expected < 150000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_dict(input int a, input logic [N-1:0] s, input logic v);
      @(negedge clk);
      dict_we = 1; dict_addr = 4'(a); dict_syn = s; dict_vld = v;
      @(negedge clk);
      dict_we = 0;
      sh_syn[a] = s; sh_vld[a] = v;
   endtask

   task automatic wr_gold(input logic [N-1:0] g);
      @(negedge clk);
      gold_we = 1; gold_data = g;
      @(negedge clk);
      gold_we = 0;
      sh_gold = g;
   endtask

   // nearest valid entry, lowest address on ties (R4, R5, R6)
   task automatic ref_diag(input logic [N-1:0] syn, output int h, output int idx, output int d);
      h = 0; idx = 0; d = 0;
      for (int e = 0; e < DEPTH; e++) begin
         int dd;
         dd = $countones(sh_syn[e] ^ syn);
         if (sh_vld[e] && (h == 0 || dd < d)) begin h = 1; idx = e; d = dd; end
      end
   endtask

   // one run; optional start poke mid-run; returns latency in edges
   task automatic run_diag(input logic [N-1:0] f, input bit poke, output int lat);
      int edges;
      logic [2:0] seen [N];
      flip = f;
      @(negedge clk); start = 1;
      @(posedge clk); edges = 1;
      @(negedge clk); start = 0;
      while (!done && edges < 100) begin
         if (edges <= N) seen[edges-1] = cut_in;
         if (poke && edges == 3) start = 1;
         @(posedge clk); edges++;
         @(negedge clk); start = 0;
      end
      lat = edges;
      for (int k = 0; k < N; k++) chk("R1 vector order", int'(seen[k]), int'(VEC[k]));
      @(negedge clk);
      chk("R7 done one cycle", int'(done), 0);
   endtask

   task automatic expect_result(input string req, input logic [N-1:0] f);
      int h, i, d, lat;
      ref_diag((TRUE_RESP ^ f) ^ sh_gold, h, i, d);
      run_diag(f, 0, lat);
      chk({req, " hit"}, int'(hit), h);
      chk({req, " index"}, int'(fault_idx), i);
      chk({req, " distance"}, int'(fault_dist), d);
   endtask

   task automatic t_reset();
      chk("R6 reset done", int'(done), 0);
      chk("R6 reset hit", int'(hit), 0);
      chk("R6 reset idx", int'(fault_idx), 0);
      chk("R1 idle bus", int'(cut_in), 0);
   endtask

   task automatic t_fault_free();
      int lat;
      run_diag('0, 0, lat);
      chk("R7 latency", lat, LAT);
      chk("R4 fault-free idx", int'(fault_idx), 0);
      chk("R4 fault-free dist", int'(fault_dist), 0);
      chk("R1 idle after run", int'(cut_in), 0);
   endtask

   task automatic t_busy_start();
      int lat;
      run_diag(4'b0101, 1, lat);
      chk("R9 start ignored latency", lat, LAT);
      chk("R9 result idx", int'(fault_idx), 3);
      repeat (30) begin
         @(negedge clk);
         chk("R9 no second done", int'(done), 0);
      end
   endtask

   task automatic t_hold();
      logic [3:0] i0; logic [2:0] d0;
      i0 = fault_idx; d0 = fault_dist;
      wr_dict(3, 4'b1111, 1);
      wr_gold(4'b0000);
      repeat (5) @(negedge clk);
      chk("R8 idx held", int'(fault_idx), int'(i0));
      chk("R8 dist held", int'(fault_dist), int'(d0));
      wr_dict(3, 4'b0101, 1);
      wr_gold(TRUE_RESP);
   endtask

   initial begin
      for (int e = 0; e < DEPTH; e++) begin sh_syn[e] = '0; sh_vld[e] = 0; end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      wr_gold(TRUE_RESP);
      wr_dict(0, 4'b0000, 1);
      wr_dict(1, 4'b0011, 1);
      wr_dict(2, 4'b1100, 1);
      wr_dict(3, 4'b0101, 1);
      wr_dict(5, 4'b1111, 0);
      t_fault_free();
      expect_result("R4 exact entry 3", 4'b0101);   // idx 3 dist 0
      expect_result("R4 nearest entry 1", 4'b1011); // idx 1 dist 1
      expect_result("R5 tie 1 vs 3", 4'b0111);      // idx 1 dist 1
      expect_result("R5 tie 0 vs 2", 4'b1000);      // idx 0 dist 1
      expect_result("R3 invalid skipped", 4'b1111); // idx 1 dist 2
      wr_dict(5, 4'b1111, 1);
      expect_result("R3 entry enabled", 4'b1111);   // idx 5 dist 0
      wr_gold(TRUE_RESP ^ 4'b0011);
      expect_result("R2 golden flips syndrome", 4'b0000); // idx 1 dist 0
      wr_gold(TRUE_RESP);
      t_busy_start();
      t_hold();
      for (int e = 0; e < DEPTH; e++) wr_dict(e, 4'b0000, 0);
      expect_result("R6 empty dictionary", 4'b0110);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule